// File: doc/BRIEF.md
# Multi-Channel ADC Conversion Sequencer

This block controls an external successive-approximation conversion engine through a start/done handshake. Software writes one control word holding a run bit, a mode bit, a channel-select field, an interrupt enable, a trigger enable and a flag write value. Setting the run bit, or a rising edge on the external trigger pin, starts a scan. In single mode the sequencer converts only the selected channel. In group mode it converts every channel from 0 up to the selected one, in ascending order and back to back. Each result goes into a result register that belongs to its channel.

When the scan ends, the run bit drops by itself and the completion flag rises. An interrupt follows if it is enabled. Writing the run bit to 0 during a scan aborts it. Any result that the engine returns afterwards for the aborted conversion is discarded, and the next start begins again at the first channel of the group. The engine, the bus bridge and any DMA sit outside this block.

Top module: `adc_scan_seq`

## Requirements
- R1: After reset, scan_active, done_flag, irq and eng_start are 0 and every result register reads 0.
- R2: With cfg_group=0 (single mode), a start converts only channel cfg_sel. Its result lands in the slot for that channel, bits [ch*DW +: DW] of result_flat. The other slots keep their values, and at the end scan_active returns to 0 and done_flag becomes 1.
- R3: With cfg_group=1 (group mode), a start converts channels 0,1,...,cfg_sel in ascending order, and each result is stored in its own slot. After each done that is not the final one, eng_start is high in the very next cycle for the next channel.
- R4: On the done of the last channel of a scan, scan_active falls and done_flag rises at the same clock edge.
- R5: One control write can change cfg_group and cfg_sel and set cfg_start together, and the scan it starts uses the newly written mode and selection.
- R6: A control write with cfg_start=0 during a scan stops it at the next edge. No result register changes afterwards, a done from the engine for the aborted conversion is ignored, and done_flag is not set.
- R7: A start after an abort begins at the first channel of the group. eng_start stays low while the engine still owes a done for the aborted conversion.
- R8: A control write with cfg_flag=0 clears done_flag only if the flag has been read as 1 through stat_rd since it was last set. A write with cfg_flag=1 never changes the flag.
- R9: When a completion and an armed clear fall in the same cycle, the flag ends up set.
- R10: irq is high exactly while done_flag is 1 and the stored interrupt enable is 1.
- R11: A rising edge on trig_pin starts a scan with the stored mode and selection only when the stored trigger enable is 1 and no scan is running. Otherwise the edge has no effect.
- R12: A control write with cfg_start=1 during a scan neither restarts nor changes the running scan.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously inside |
| cfg_wr | input | 1 | Control write strobe, one cycle |
| cfg_start | input | 1 | Run bit value written |
| cfg_group | input | 1 | 1 = group mode, 0 = single mode |
| cfg_sel | input | CHW | Channel select (single) or last channel (group) |
| cfg_flag | input | 1 | Flag write value; 0 requests a clear |
| cfg_irq_en | input | 1 | Interrupt enable value written |
| cfg_trig_en | input | 1 | External trigger enable value written |
| stat_rd | input | 1 | Status read strobe; arms the flag clear when done_flag is 1 |
| trig_pin | input | 1 | Asynchronous external trigger |
| eng_done | input | 1 | Engine done pulse, one cycle |
| eng_data | input | DW | Engine result, valid with eng_done |
| eng_start | output | 1 | Engine start pulse |
| eng_ch | output | CHW | Channel for the engine, valid with eng_start |
| scan_active | output | 1 | Run bit readback |
| done_flag | output | 1 | Completion flag |
| irq | output | 1 | Interrupt request |
| result_flat | output | NCH*DW | All result registers, channel k at [k*DW +: DW] |

## Verification
The assertions assume the engine returns exactly one eng_done for each eng_start and never raises a done that it does not owe. Under that assumption, a done seen in the wait state always belongs to the current channel. The bench engine model follows that contract with a fixed latency. After an abort it still delivers the outstanding done, and it records that result as discarded. Control writes are driven away from clock edges and held for one cycle. The one write that coincides with a completion is timed from the model's own done pulse.

// File: rtl/adc_seq_pkg.sv
package adc_seq_pkg;
  typedef enum logic [1:0] {
    ST_IDLE  = 2'd0,
    ST_ISSUE = 2'd1,
    ST_WAIT  = 2'd2
  } seq_st_e;
endpackage

// File: rtl/adc_trig_edge.sv
module adc_trig_edge #(
  parameter int STAGES = 2
) (
  input  logic clk,
  input  logic rst_n,
  input  logic pin,
  output logic rise
);
  logic [STAGES:0] sh_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) sh_q <= '0;
    else        sh_q <= {sh_q[STAGES-1:0], pin};
  end

  assign rise = sh_q[STAGES-1] & ~sh_q[STAGES];
endmodule

// File: rtl/adc_flag_ctl.sv
module adc_flag_ctl (
  input  logic clk,
  input  logic rst_n,
  input  logic set_i,
  input  logic rd_i,
  input  logic clr_i,
  output logic flag_o
);
  logic flag_q, flag_d, armed_q, armed_d;

  always_comb begin
    flag_d  = flag_q;
    armed_d = armed_q;
    if (rd_i && flag_q) armed_d = 1'b1;
    if (clr_i && armed_q) begin
      flag_d  = 1'b0;
      armed_d = 1'b0;
    end
    if (set_i) begin
      flag_d  = 1'b1;
      armed_d = 1'b0;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      flag_q  <= 1'b0;
      armed_q <= 1'b0;
    end else begin
      flag_q  <= flag_d;
      armed_q <= armed_d;
    end
  end

  assign flag_o = flag_q;
endmodule

// File: rtl/adc_result_bank.sv
module adc_result_bank #(
  parameter int NCH = 4,
  parameter int DW  = 10,
  localparam int CHW = (NCH > 1) ? $clog2(NCH) : 1
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              we,
  input  logic [CHW-1:0]    wch,
  input  logic [DW-1:0]     wdata,
  output logic [NCH*DW-1:0] res_flat
);
  for (genvar k = 0; k < NCH; k++) begin : g_slot
    logic [DW-1:0] slot_q;
    logic          slot_en;
    assign slot_en = we && (wch == CHW'(k));
    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)       slot_q <= '0;
      else if (slot_en) slot_q <= wdata;
    end
    assign res_flat[k*DW +: DW] = slot_q;
  end
endmodule

// File: rtl/adc_scan_seq.sv
module adc_scan_seq
  import adc_seq_pkg::*;
#(
  parameter int NCH = 4,
  parameter int DW  = 10,
  localparam int CHW = (NCH > 1) ? $clog2(NCH) : 1
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              cfg_wr,
  input  logic              cfg_start,
  input  logic              cfg_group,
  input  logic [CHW-1:0]    cfg_sel,
  input  logic              cfg_flag,
  input  logic              cfg_irq_en,
  input  logic              cfg_trig_en,
  input  logic              stat_rd,
  input  logic              trig_pin,
  input  logic              eng_done,
  input  logic [DW-1:0]     eng_data,
  output logic              eng_start,
  output logic [CHW-1:0]    eng_ch,
  output logic              scan_active,
  output logic              done_flag,
  output logic              irq,
  output logic [NCH*DW-1:0] result_flat
);
  // reset: asynchronous assert, synchronous release
  logic rst_q1, rst_s_n;
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) {rst_s_n, rst_q1} <= 2'b00;
    else        {rst_s_n, rst_q1} <= {rst_q1, 1'b1};
  end

  // stored configuration, loaded on every control write
  logic           grp_q, ien_q, ten_q;
  logic [CHW-1:0] sel_q;
  always_ff @(posedge clk or negedge rst_s_n) begin
    if (!rst_s_n) begin
      grp_q <= 1'b0;
      sel_q <= '0;
      ien_q <= 1'b0;
      ten_q <= 1'b0;
    end else if (cfg_wr) begin
      grp_q <= cfg_group;
      sel_q <= cfg_sel;
      ien_q <= cfg_irq_en;
      ten_q <= cfg_trig_en;
    end
  end

  logic trig_rise;
  adc_trig_edge #(.STAGES(2)) u_trig (
    .clk (clk), .rst_n (rst_s_n), .pin (trig_pin), .rise (trig_rise)
  );

  // sequencer state
  seq_st_e        st_q, st_d;
  logic [CHW-1:0] ch_q, ch_d, last_q, last_d;
  logic           pend_q, pend_d;
  logic           busy, abort, sw_go, hw_go, accept, is_last;

  assign busy    = (st_q != ST_IDLE);
  assign abort   = cfg_wr && !cfg_start && busy;
  assign sw_go   = cfg_wr && cfg_start && !busy;
  assign hw_go   = !cfg_wr && trig_rise && ten_q && !busy;
  assign is_last = (ch_q == last_q);
  assign accept  = (st_q == ST_WAIT) && eng_done && !abort;
  assign eng_start = (st_q == ST_ISSUE) && !pend_q && !abort;

  always_comb begin
    st_d   = st_q;
    ch_d   = ch_q;
    last_d = last_q;
    unique case (st_q)
      ST_IDLE: begin
        if (sw_go) begin
          ch_d   = cfg_group ? '0 : cfg_sel;
          last_d = cfg_sel;
          st_d   = ST_ISSUE;
        end else if (hw_go) begin
          ch_d   = grp_q ? '0 : sel_q;
          last_d = sel_q;
          st_d   = ST_ISSUE;
        end
      end
      ST_ISSUE: begin
        if (abort)        st_d = ST_IDLE;
        else if (!pend_q) st_d = ST_WAIT;
      end
      ST_WAIT: begin
        if (abort) st_d = ST_IDLE;
        else if (eng_done) begin
          if (is_last) st_d = ST_IDLE;
          else begin
            ch_d = ch_q + CHW'(1);
            st_d = ST_ISSUE;
          end
        end
      end
      default: st_d = ST_IDLE;
    endcase
  end

  // the engine owes one done for every start
  always_comb begin
    pend_d = pend_q;
    if (eng_done)  pend_d = 1'b0;
    if (eng_start) pend_d = 1'b1;
  end

  always_ff @(posedge clk or negedge rst_s_n) begin
    if (!rst_s_n) begin
      st_q   <= ST_IDLE;
      ch_q   <= '0;
      last_q <= '0;
      pend_q <= 1'b0;
    end else begin
      st_q   <= st_d;
      ch_q   <= ch_d;
      last_q <= last_d;
      pend_q <= pend_d;
    end
  end

  adc_result_bank #(.NCH(NCH), .DW(DW)) u_bank (
    .clk (clk), .rst_n (rst_s_n), .we (accept), .wch (ch_q),
    .wdata (eng_data), .res_flat (result_flat)
  );

  adc_flag_ctl u_flag (
    .clk (clk), .rst_n (rst_s_n), .set_i (accept && is_last),
    .rd_i (stat_rd), .clr_i (cfg_wr && !cfg_flag), .flag_o (done_flag)
  );

  assign eng_ch      = ch_q;
  assign scan_active = busy;
  assign irq         = done_flag && ien_q;
endmodule

// File: rtl/adc_scan_seq_chk.sv
module adc_scan_seq_chk
  import adc_seq_pkg::*;
#(
  parameter int NCH = 4,
  parameter int DW  = 10,
  localparam int CHW = (NCH > 1) ? $clog2(NCH) : 1
) (
  input logic              clk,
  input logic              rst_n,
  input logic              cfg_wr,
  input logic              cfg_start,
  input logic              cfg_flag,
  input logic              eng_done,
  input logic              eng_start,
  input logic [CHW-1:0]    eng_ch,
  input logic              scan_active,
  input logic              done_flag,
  input logic              irq,
  input logic [NCH*DW-1:0] result_flat,
  input seq_st_e           st_q,
  input logic [CHW-1:0]    ch_q,
  input logic [CHW-1:0]    last_q
);
  logic kill;
  assign kill = cfg_wr && !cfg_start;

  // R6
  abort_stop_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (kill && scan_active) |=> (!scan_active && !eng_start));

  // R6
  idle_done_ignored_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (!scan_active && eng_done) |=> $stable(result_flat));

  // R4
  last_done_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (st_q == ST_WAIT && eng_done && ch_q == last_q && !kill) |=> (!scan_active && done_flag));

  // R3
  gapless_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (st_q == ST_WAIT && eng_done && ch_q != last_q && !kill)
      |=> (eng_start && eng_ch == ($past(ch_q) + CHW'(1))));

  // R8
  flag_clear_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(done_flag) |-> $past(cfg_wr && !cfg_flag));

  // R12
  restart_ignored_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (scan_active && cfg_wr && cfg_start && !eng_done) |=> ($stable(ch_q) && scan_active));

  // R10
  irq_flag_chk: assert property (@(posedge clk) disable iff (!rst_n)
    irq |-> done_flag);
endmodule

bind adc_scan_seq adc_scan_seq_chk #(.NCH(NCH), .DW(DW)) u_chk (
  .clk (clk), .rst_n (rst_n), .cfg_wr (cfg_wr), .cfg_start (cfg_start),
  .cfg_flag (cfg_flag), .eng_done (eng_done), .eng_start (eng_start),
  .eng_ch (eng_ch), .scan_active (scan_active), .done_flag (done_flag),
  .irq (irq), .result_flat (result_flat), .st_q (st_q), .ch_q (ch_q),
  .last_q (last_q)
);

// File: tb/sim_adc_scan_seq.sv
`timescale 1ns/1ps
module sim_adc_scan_seq;
  localparam int NCH = 4;
  localparam int DW  = 10;
  localparam int LAT = 5;

  logic clk, rst_n;
  logic cfg_wr, cfg_start, cfg_group, cfg_flag, cfg_irq_en, cfg_trig_en;
  logic [1:0] cfg_sel;
  logic stat_rd, trig_pin, eng_done;
  logic [DW-1:0] eng_data;
  logic eng_start;
  logic [1:0] eng_ch;
  logic scan_active, done_flag, irq;
  logic [NCH*DW-1:0] result_flat;

  adc_scan_seq #(.NCH(NCH), .DW(DW)) u0 (
    .clk (clk), .rst_n (rst_n), .cfg_wr (cfg_wr), .cfg_start (cfg_start),
    .cfg_group (cfg_group), .cfg_sel (cfg_sel), .cfg_flag (cfg_flag),
    .cfg_irq_en (cfg_irq_en), .cfg_trig_en (cfg_trig_en), .stat_rd (stat_rd),
    .trig_pin (trig_pin), .eng_done (eng_done), .eng_data (eng_data),
    .eng_start (eng_start), .eng_ch (eng_ch), .scan_active (scan_active),
    .done_flag (done_flag), .irq (irq), .result_flat (result_flat)
  );

  initial clk = 1'b0;
  always #4 clk = ~clk;

  int n_chk = 0, n_fail = 0, n_starts = 0, serial = 0, e_cnt = 0;
  logic [1:0] e_ch;
  logic drop_next = 1'b0;
  logic [DW-1:0] model_res [NCH];
  logic [1:0] exp_q [$];
  logic cur_ie = 1'b0, cur_te = 1'b0;

  task automatic chk(input logic ok, input string tag, input longint act, input longint exp);
    n_chk++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s act=%0h exp=%0h", tag, act, exp);
    end
  endtask

  // engine model: fixed latency, one done per start
  initial begin
    eng_done = 1'b0;
    eng_data = '0;
    for (int k = 0; k < NCH; k++) model_res[k] = '0;
  end
  always @(negedge clk) begin
    eng_done <= 1'b0;
    if (e_cnt > 0) begin
      e_cnt = e_cnt - 1;
      if (e_cnt == 0) begin
        eng_done <= 1'b1;
        eng_data <= {e_ch, serial[7:0]};
        if (drop_next) drop_next = 1'b0;
        else model_res[e_ch] = {e_ch, serial[7:0]};
        serial++;
      end
    end
    if (rst_n && eng_start) begin
      e_cnt = LAT;
      e_ch  = eng_ch;
    end
  end

  // scoreboard monitor: every engine start must match the next expected channel
  always @(negedge clk) begin
    if (rst_n && eng_start) begin
      n_starts++;
      if (exp_q.size() == 0) chk(1'b0, "R7/R11 unexpected engine start", eng_ch, 0);
      else begin
        automatic logic [1:0] e = exp_q.pop_front();
        chk(eng_ch == e, "R3 channel order", eng_ch, e);
      end
    end
  end

  task automatic wr(input logic st, input logic grp, input logic [1:0] sel,
                    input logic fl, input logic ie, input logic te);
    @(negedge clk); #1;
    cfg_wr = 1'b1; cfg_start = st; cfg_group = grp; cfg_sel = sel;
    cfg_flag = fl; cfg_irq_en = ie; cfg_trig_en = te;
    cur_ie = ie; cur_te = te;
    @(negedge clk); #1;
    cfg_wr = 1'b0;
  endtask

  task automatic push_scan(input logic grp, input logic [1:0] sel);
    if (grp) for (int k = 0; k <= sel; k++) exp_q.push_back(2'(k));
    else exp_q.push_back(sel);
  endtask

  task automatic rd_flag();
    @(negedge clk); #1; stat_rd = 1'b1;
    @(negedge clk); #1; stat_rd = 1'b0;
  endtask

  task automatic wait_idle();
    for (int i = 0; i < 300; i++) begin
      @(negedge clk); #1;
      if (!scan_active) break;
    end
  endtask

  task automatic chk_results(input string tag);
    for (int k = 0; k < NCH; k++)
      chk(result_flat[k*DW +: DW] == model_res[k], tag, result_flat[k*DW +: DW], model_res[k]);
  endtask

  task automatic trig_pulse();
    @(negedge clk); #1; trig_pin = 1'b1;
    repeat (3) @(negedge clk);
    #1; trig_pin = 1'b0;
  endtask

  task automatic summary();
    $display("TB_RESULT checks=%0d failures=%0d", n_chk, n_fail);
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    n_fail++;
    $display("FAIL watchdog expired");
    summary();
    $finish;
  end

  initial begin
    int base;
    rst_n = 1'b0; cfg_wr = 0; cfg_start = 0; cfg_group = 0; cfg_sel = 0;
    cfg_flag = 1; cfg_irq_en = 0; cfg_trig_en = 0; stat_rd = 0; trig_pin = 0;
    repeat (3) @(negedge clk);
    #1 rst_n = 1'b1;
    repeat (4) @(negedge clk);
    #1;
    // R1 reset state
    chk(!scan_active && !done_flag && !irq && !eng_start, "R1 reset outputs",
        {scan_active, done_flag, irq, eng_start}, 0);
    chk(result_flat == '0, "R1 results zero", result_flat, 0);

    // R2/R5: single mode, mode and selection written together with start
    push_scan(1'b0, 2'd2);
    wr(1, 0, 2'd2, 1, 1, 0);
    chk(scan_active, "R5 start with new settings", scan_active, 1);
    wait_idle();
    chk(!scan_active && done_flag, "R2 single done", {scan_active, done_flag}, 2'b01);
    chk(result_flat[2*DW +: DW] == model_res[2] && model_res[2] != 0, "R2 selected slot",
        result_flat[2*DW +: DW], model_res[2]);
    chk(result_flat[0 +: DW] == '0, "R2 other slot untouched", result_flat[0 +: DW], 0);
    chk(irq, "R10 irq when enabled", irq, 1);

    // R8: clear without a prior read is ignored, a write with flag=1 too
    wr(0, 0, 2'd2, 0, 1, 0);
    chk(done_flag, "R8 clear needs read", done_flag, 1);
    rd_flag();
    wr(0, 0, 2'd2, 1, 1, 0);
    chk(done_flag, "R8 flag write 1 no effect", done_flag, 1);
    wr(0, 0, 2'd2, 0, 1, 0);
    chk(!done_flag && !irq, "R8 armed clear", {done_flag, irq}, 0);

    // R3/R4: group of four, gapless issue
    push_scan(1'b1, 2'd3);
    wr(1, 1, 2'd3, 1, 1, 0);
    for (int i = 0; i < 200; i++) begin
      @(negedge clk); #1;
      if (eng_done && e_ch == 2'd1) break;
    end
    chk(!done_flag, "R4 flag not before last", done_flag, 0);
    @(negedge clk); #1;
    chk(eng_start && eng_ch == 2'd2, "R3 next start in next cycle", {eng_start, eng_ch}, 3'b110);
    for (int i = 0; i < 200; i++) begin
      @(negedge clk); #1;
      if (!scan_active) break;
    end
    chk(done_flag, "R4 flag with run bit drop", done_flag, 1);
    chk_results("R3 group results");

    // R5/R10: new group size with interrupt disabled
    rd_flag(); wr(0, 1, 2'd3, 0, 0, 0);
    push_scan(1'b1, 2'd1);
    wr(1, 1, 2'd1, 1, 0, 0);
    wait_idle();
    chk(done_flag && !irq, "R10 irq masked", {done_flag, irq}, 2'b10);
    chk_results("R5 two channel group");

    // R6: abort mid scan, pending done discarded
    rd_flag(); wr(0, 1, 2'd1, 0, 1, 0);
    push_scan(1'b1, 2'd3);
    base = n_starts;
    wr(1, 1, 2'd3, 1, 1, 0);
    while (n_starts < base + 2) @(negedge clk);
    repeat (2) @(negedge clk);
    drop_next = 1'b1;
    exp_q.delete();
    wr(0, 1, 2'd3, 1, 1, 0);
    chk(!scan_active, "R6 abort stops", scan_active, 0);
    repeat (12) @(negedge clk);
    #1;
    chk(!done_flag, "R6 no flag on abort", done_flag, 0);
    chk_results("R6 aborted result not stored");

    // R7: abort then immediate restart while engine still busy
    push_scan(1'b1, 2'd3);
    base = n_starts;
    wr(1, 1, 2'd3, 1, 1, 0);
    while (n_starts < base + 2) @(negedge clk);
    drop_next = 1'b1;
    exp_q.delete();
    wr(0, 1, 2'd3, 1, 1, 0);
    push_scan(1'b1, 2'd3);
    wr(1, 1, 2'd3, 1, 1, 0);
    for (int i = 0; i < 20; i++) begin
      chk(!eng_start, "R7 no start while engine owes done", eng_start, 0);
      if (eng_done) break;
      @(negedge clk); #1;
    end
    wait_idle();
    chk_results("R7 restart from first channel");

    // R12: start write during scan is ignored
    rd_flag(); wr(0, 1, 2'd3, 0, 1, 0);
    push_scan(1'b1, 2'd3);
    base = n_starts;
    wr(1, 1, 2'd3, 1, 1, 0);
    while (n_starts < base + 1) @(negedge clk);
    wr(1, 0, 2'd0, 1, 1, 0);
    wait_idle();
    chk(n_starts == base + 4, "R12 scan not restarted", n_starts - base, 4);
    chk_results("R12 results");

    // R11: trigger disabled then enabled, ignored while busy
    wr(0, 1, 2'd1, 1, 1, 0);
    base = n_starts;
    trig_pulse();
    repeat (10) @(negedge clk);
    #1;
    chk(!scan_active && n_starts == base, "R11 trigger disabled", n_starts - base, 0);
    wr(0, 1, 2'd1, 1, 1, 1);
    push_scan(1'b1, 2'd1);
    trig_pulse();
    @(negedge clk); #1;
    chk(scan_active, "R11 trigger started scan", scan_active, 1);
    trig_pulse();
    wait_idle();
    repeat (12) @(negedge clk);
    #1;
    chk(n_starts == base + 2, "R11 trigger while busy ignored", n_starts - base, 2);
    chk_results("R11 trigger results");

    // R9: armed clear in the completion cycle loses to the set
    rd_flag();
    push_scan(1'b0, 2'd3);
    wr(1, 0, 2'd3, 1, 1, 0);
    for (int i = 0; i < 50; i++) begin
      @(negedge clk); #1;
      if (eng_done) break;
    end
    cfg_wr = 1'b1; cfg_start = 1'b1; cfg_flag = 1'b0;
    @(negedge clk); #1;
    cfg_wr = 1'b0; cfg_flag = 1'b1;
    chk(done_flag && !scan_active, "R9 set beats clear", {done_flag, scan_active}, 2'b10);
    chk_results("R9 single result");

    chk(exp_q.size() == 0, "R3 scoreboard drained", exp_q.size(), 0);
    summary();
    $finish;
  end
endmodule